// File: doc/BRIEF.md
# Prescaled PWM Generator with Register Control

This block produces one pulse-width-modulated output from a small register file. Software stores an 8-bit compare value, a polarity bit and a power-of-two prescaler code in a configuration register. A separate register picks the counting source, either the system clock (every cycle a tick) or the rising edges of an asynchronous slow clock input. One output period is always 256 prescaled ticks. The output is in its active state while the period counter is below the compare value, so the duty cycle runs from 0/256 to 255/256 and never reaches a full period.

Starting and stopping use two separate write-one strobe registers. The request passes through a two-stage chain that advances on counting ticks, and a status bit reports the chain's output, so software can poll it to see whether the generator really runs. A configuration change made while running is held in a shadow copy until the counter wraps from 255 to 0, which keeps every period glitch-free. While stopped, the counter sits at zero and the output rests at its inactive level.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset the configuration register reads 0, the status register reads 0, the source select reads 0 (slow clock) and `pwm_o` is 1.
- R2: The configuration register is at address 0 and holds the compare value in bits 15:8, the polarity bit in bit 4 and the prescaler code in bits 2:0; all other bits read 0.
- R3: A configuration write whose prescaler code is 7 is rejected as a whole and the register keeps its previous contents.
- R4: With prescaler code n (0 to 6) each counter step takes 2^n ticks, a period is 256 steps, and the output is active for exactly compare × 2^n ticks per period.
- R5: A compare value of 0 gives a constantly inactive output; a compare value of 255 gives 255 active steps per period, so the output is inactive at least at count 255.
- R6: With bit 4 set the active level is 1; with bit 4 clear the active level is 0 and the output is inverted.
- R7: Address 1 bit 0 selects the counting source: 1 counts every system clock cycle, 0 counts each rising edge of `slow_clk`.
- R8: Writing bit 0 = 1 to address 2 starts the generator; status (address 4, bit 0) becomes 1 two ticks after the write. Writing bit 0 = 0 there has no effect.
- R9: Writing bit 0 = 1 to address 3 stops the generator; status becomes 0 two ticks after the write, the counter is held at zero and the output sits at its inactive level.
- R10: A compare or prescaler change written while running takes effect only when the counter wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Asynchronous slow clock, sampled as a tick source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
Register reads are combinational, so read-back is sampled half a cycle after the address changes, and a write is seen one edge after the strobe. In system-clock mode the status bit is sampled one cycle after the write edge (still old) and two cycles after (new), pinning the two-tick lag. Duty is measured by counting active samples at falling edges over a window of exactly 256 × 2^n cycles once the status bit is set; any such window in steady state holds compare × 2^n active cycles regardless of phase, and the compare values are swept exhaustively. The wrap rule is checked by locking onto the period start at the first active sample and writing mid-period, where the old and new compares predict different levels on the next cycle.

// File: rtl/pwm_prescaled_pkg.sv
package pwm_prescaled_pkg;

   localparam int REG_AW = 3;

   // register addresses
   typedef enum logic [REG_AW-1:0] {
      RA_CFG    = 3'd0,
      RA_SRCSEL = 3'd1,
      RA_START  = 3'd2,
      RA_STOP   = 3'd3,
      RA_STATUS = 3'd4
   } reg_addr_e;

   // field placement inside the configuration word
   localparam int CMP_LSB = 8;
   localparam int POL_BIT = 4;
   localparam int PS_LSB  = 0;

endpackage

// File: rtl/pwm_prescaled_regs.sv
module pwm_prescaled_regs
   import pwm_prescaled_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PS_W   = 3,
   parameter int PS_MAX = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              running,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  cfg_cmp,
   output logic              cfg_pol,
   output logic [PS_W-1:0]   cfg_ps,
   output logic              sel_sys,
   output logic              run_req
);

   logic [PS_W-1:0]  ps_new;
   logic [CNT_W-1:0] cmp_new;
   logic             ps_ok;

   assign ps_new  = wdata[PS_LSB +: PS_W];
   assign cmp_new = wdata[CMP_LSB +: CNT_W];
   assign ps_ok   = (int'(ps_new) <= PS_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_cmp <= '0;
         cfg_pol <= 1'b0;
         cfg_ps  <= '0;
         sel_sys <= 1'b0;
         run_req <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            RA_CFG: begin
               if (ps_ok) begin
                  cfg_cmp <= cmp_new;
                  cfg_pol <= wdata[POL_BIT];
                  cfg_ps  <= ps_new;
               end
            end
            RA_SRCSEL: sel_sys <= wdata[0];
            RA_START:  if (wdata[0]) run_req <= 1'b1;
            RA_STOP:   if (wdata[0]) run_req <= 1'b0;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CFG: begin
            rdata[CMP_LSB +: CNT_W] = cfg_cmp;
            rdata[POL_BIT]          = cfg_pol;
            rdata[PS_LSB +: PS_W]   = cfg_ps;
         end
         RA_SRCSEL: rdata[0] = sel_sys;
         RA_STATUS: rdata[0] = running;
         default: ;
      endcase
   end

endmodule

// File: rtl/pwm_prescaled_tick_src.sv
module pwm_prescaled_tick_src #(
   parameter int SLOW_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_clk,
   input  logic sel_sys,
   output logic tick
);

   // SLOW_SYNC stages of synchronizer plus one stage for edge detection
   logic [SLOW_SYNC:0] samp;

   genvar g;
   generate
      for (g = 0; g <= SLOW_SYNC; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) samp[g] <= 1'b0;
               else        samp[g] <= slow_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) samp[g] <= 1'b0;
               else        samp[g] <= samp[g-1];
            end
         end
      end
   endgenerate

   logic slow_rise;
   assign slow_rise = samp[SLOW_SYNC-1] & ~samp[SLOW_SYNC];
   assign tick      = sel_sys | slow_rise;

endmodule

// File: rtl/pwm_prescaled_run_sync.sv
module pwm_prescaled_run_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run_req,
   output logic running
);

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         logic d;
         if (g == 0) begin : g_in
            assign d = run_req;
         end else begin : g_mid
            assign d = chain[g-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    chain[g] <= 1'b0;
            else if (tick) chain[g] <= d;
         end
      end
   endgenerate

   assign running = chain[STAGES-1];

endmodule

// File: rtl/pwm_prescaled_core.sv
module pwm_prescaled_core #(
   parameter int CNT_W  = 8,
   parameter int PS_W   = 3,
   parameter int PS_MAX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             running,
   input  logic [CNT_W-1:0] cfg_cmp,
   input  logic             cfg_pol,
   input  logic [PS_W-1:0]  cfg_ps,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_tick,
   output logic [CNT_W-1:0] act_cmp,
   output logic             act_pol,
   output logic             pwm_o
);

   localparam int                PRE_W    = PS_MAX;
   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   logic [PS_W-1:0]  act_ps;
   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] pre_last;
   logic             pre_hit;
   logic             wrap;
   logic             window;

   // last prescaler count of a counter step: 2^n - 1
   assign span     = ((PRE_W+1)'(1) << act_ps) - (PRE_W+1)'(1);
   assign pre_last = span[PRE_W-1:0];
   assign pre_hit  = (pre_cnt == pre_last);
   assign cnt_tick = running & tick & pre_hit;
   assign wrap     = cnt_tick & (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         cnt     <= '0;
      end else if (!running) begin
         pre_cnt <= '0;
         cnt     <= '0;
      end else if (tick) begin
         if (pre_hit) begin
            pre_cnt <= '0;
            cnt     <= cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   // shadow copy: tracks the register while idle, reloads at the wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cmp <= '0;
         act_pol <= 1'b0;
         act_ps  <= '0;
      end else if (!running || wrap) begin
         act_cmp <= cfg_cmp;
         act_pol <= cfg_pol;
         act_ps  <= cfg_ps;
      end
   end

   assign window = (cnt < act_cmp);
   assign pwm_o  = running ? (window == act_pol) : ~act_pol;

endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
   import pwm_prescaled_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int PS_W      = 3,
   parameter int PS_MAX    = 6,
   parameter int DATA_W    = 32,
   parameter int RUN_SYNC  = 2,
   parameter int SLOW_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_o
);

   // elaboration-time parameter checks
   generate
      if (PS_MAX < 1 || PS_MAX >= (1 << PS_W)) begin : g_bad_psmax
         $error("PS_MAX must be at least 1 and below 2**PS_W");
      end
      if (PS_LSB + PS_W > POL_BIT) begin : g_bad_psw
         $error("prescaler field overlaps the polarity bit");
      end
      if (CMP_LSB + CNT_W > DATA_W) begin : g_bad_cmp
         $error("compare field does not fit in DATA_W");
      end
      if (RUN_SYNC < 2 || SLOW_SYNC < 2) begin : g_bad_sync
         $error("synchronizers need at least two stages");
      end
   endgenerate

   logic [CNT_W-1:0] cfg_cmp;
   logic             cfg_pol;
   logic [PS_W-1:0]  cfg_ps;
   logic             sel_sys;
   logic             run_req;
   logic             running;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             cnt_tick;
   logic [CNT_W-1:0] act_cmp;
   logic             act_pol;

   pwm_prescaled_regs #(
      .CNT_W (CNT_W),
      .PS_W  (PS_W),
      .PS_MAX(PS_MAX),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .running(running),
      .rdata  (rdata),
      .cfg_cmp(cfg_cmp),
      .cfg_pol(cfg_pol),
      .cfg_ps (cfg_ps),
      .sel_sys(sel_sys),
      .run_req(run_req)
   );

   pwm_prescaled_tick_src #(
      .SLOW_SYNC(SLOW_SYNC)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .slow_clk(slow_clk),
      .sel_sys (sel_sys),
      .tick    (tick)
   );

   pwm_prescaled_run_sync #(
      .STAGES(RUN_SYNC)
   ) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .run_req(run_req),
      .running(running)
   );

   pwm_prescaled_core #(
      .CNT_W (CNT_W),
      .PS_W  (PS_W),
      .PS_MAX(PS_MAX)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .running (running),
      .cfg_cmp (cfg_cmp),
      .cfg_pol (cfg_pol),
      .cfg_ps  (cfg_ps),
      .cnt     (cnt),
      .cnt_tick(cnt_tick),
      .act_cmp (act_cmp),
      .act_pol (act_pol),
      .pwm_o   (pwm_o)
   );

endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk
   import pwm_prescaled_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PS_W   = 3,
   parameter int PS_MAX = 6,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              pwm_o,
   input logic [CNT_W-1:0]  cfg_cmp,
   input logic              cfg_pol,
   input logic [PS_W-1:0]   cfg_ps,
   input logic              running,
   input logic [CNT_W-1:0]  cnt,
   input logic              cnt_tick,
   input logic [CNT_W-1:0]  act_cmp,
   input logic              act_pol
);

   localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

   logic bad_ps_write;
   assign bad_ps_write = wr_en && (addr == RA_CFG) &&
                         (int'(wdata[PS_LSB +: PS_W]) > PS_MAX);

   assert_bad_ps_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bad_ps_write |=> $stable({cfg_cmp, cfg_pol, cfg_ps}));

   assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (cnt == '0));

   assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (pwm_o == !act_pol));

   assert_zero_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cmp == '0) |-> (pwm_o == !act_pol));

   assert_no_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == CNT_LAST) |-> (pwm_o == !act_pol));

   assert_window_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt < act_cmp) |-> (pwm_o == act_pol));

   assert_wrap_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$stable(act_cmp)) |->
         ($past(cnt) == CNT_LAST && $past(cnt_tick)));

endmodule

bind pwm_prescaled pwm_prescaled_chk #(
   .CNT_W (CNT_W),
   .PS_W  (PS_W),
   .PS_MAX(PS_MAX),
   .DATA_W(DATA_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .pwm_o   (pwm_o),
   .cfg_cmp (cfg_cmp),
   .cfg_pol (cfg_pol),
   .cfg_ps  (cfg_ps),
   .running (running),
   .cnt     (cnt),
   .cnt_tick(cnt_tick),
   .act_cmp (act_cmp),
   .act_pol (act_pol)
);

// File: tb/pwm_prescaled_bench.sv
`timescale 1ns/1ps
module pwm_prescaled_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   pwm_prescaled u_pwm_prescaled (
      .clk     (clk),
      .rst_n   (rst_n),
      .slow_clk(slow_clk),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pwm_o   (pwm_o)
   );

   // slow clock: period of 8 system cycles
   initial begin
      forever begin
         repeat (4) @(negedge clk);
         slow_clk = ~slow_clk;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic logic [31:0] cfg_word(input int cmp, input bit pol, input int ps);
      return (32'(cmp) << 8) | (32'(pol) << 4) | 32'(ps);
   endfunction

   // counts active samples (pwm_o == pol) over n cycles
   task automatic measure(input int n, input bit pol, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_o == pol) cnt++;
      end
   endtask

   task automatic run_cfg(input int cmp, input bit pol, input int ps, output int act);
      wr(3'd3, 32'd1);
      repeat (4) @(negedge clk);
      wr(3'd0, cfg_word(cmp, pol, ps));
      wr(3'd2, 32'd1);
      repeat (4) @(negedge clk);
      measure(256 << ps, pol, act);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int act;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); chk("R1 cfg after reset", d, 0);
      rd(3'd4, d); chk("R1 status after reset", d, 0);
      rd(3'd1, d); chk("R1 source select after reset", d, 0);
      chk("R1 pwm_o after reset", pwm_o, 1);

      // R7 select system clock
      wr(3'd1, 32'd1);
      rd(3'd1, d); chk("R7 source select readback", d, 1);

      // R2 field layout, extra bits dropped
      wr(3'd0, 32'hFFFF_A5F5);
      rd(3'd0, d); chk("R2 cfg readback", d, 32'h0000_A515);

      // R3 prescaler code 7 rejected
      wr(3'd0, 32'h0000_3307);
      rd(3'd0, d); chk("R3 cfg kept after code 7", d, 32'h0000_A515);

      // R8 start with bit0 clear has no effect
      wr(3'd2, 32'd0);
      repeat (4) @(negedge clk);
      rd(3'd4, d); chk("R8 start with bit0=0 ignored", d, 0);

      // R8 status lag in system-clock mode
      wr(3'd0, cfg_word(8'h40, 1'b1, 0));
      wr(3'd2, 32'd1);
      addr = 3'd4;
      @(negedge clk); chk("R8 status one cycle after start", rdata[0], 0);
      @(negedge clk); chk("R8 status two cycles after start", rdata[0], 1);

      // R9 stop: status lag, inactive output
      wr(3'd3, 32'd1);
      addr = 3'd4;
      @(negedge clk); chk("R9 status one cycle after stop", rdata[0], 1);
      @(negedge clk); chk("R9 status two cycles after stop", rdata[0], 0);
      measure(300, 1'b1, act); chk("R9 idle output inactive pol=1", act, 0);
      wr(3'd0, cfg_word(8'h40, 1'b0, 0));
      repeat (2) @(negedge clk);
      chk("R9 R6 idle output level pol=0", pwm_o, 1);

      // R4 R5 R6 exhaustive compare sweep at prescaler 0, alternating polarity
      for (int c = 0; c < 256; c++) begin
         run_cfg(c, c[0], 0, act);
         chk($sformatf("R4 R5 R6 duty cmp=%0d", c), act, c);
      end

      // R4 every legal prescaler code
      for (int p = 1; p <= 6; p++) begin
         run_cfg(8'h40, 1'b1, p, act);
         chk($sformatf("R4 duty prescaler=%0d", p), act, 8'h40 << p);
      end

      // R10 compare change mid-period waits for the wrap
      run_cfg(8'h80, 1'b1, 0, act);
      @(negedge clk);
      while (pwm_o != 1'b0) @(negedge clk);
      while (pwm_o != 1'b1) @(negedge clk);
      repeat (8'h40) @(negedge clk);
      wr(3'd0, cfg_word(8'h20, 1'b1, 0));
      chk("R10 old compare kept mid-period", pwm_o, 1);
      @(negedge clk);
      chk("R10 old compare kept next cycle", pwm_o, 1);
      while (pwm_o != 1'b0) @(negedge clk);
      while (pwm_o != 1'b1) @(negedge clk);
      act = 1;
      for (int i = 1; i < 256; i++) begin
         @(negedge clk);
         if (pwm_o) act++;
      end
      chk("R10 new compare after wrap", act, 8'h20);

      // R7 slow clock source: 8 system cycles per tick
      wr(3'd3, 32'd1);
      repeat (8) @(negedge clk);
      wr(3'd1, 32'd0);
      wr(3'd0, cfg_word(8'h80, 1'b1, 0));
      wr(3'd2, 32'd1);
      addr = 3'd4;
      @(negedge clk); chk("R7 R8 status still low on slow clock", rdata[0], 0);
      repeat (60) @(negedge clk);
      chk("R7 R8 status high on slow clock", rdata[0], 1);
      measure(2048, 1'b1, act);
      chk("R7 duty on slow clock", act, 1024);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule